// File: doc/BRIEF.md
# Status LED Matrix Scanner

This block shows the on/off state of eight output channels on a small LED array wired as four rows by two columns. Each row holds the LEDs for a fixed pair of channels. The scanner turns on one row at a time in a fixed rotation. While a row is on, it drives each column high if the matching channel is on.

The row outputs are active-low sink enables, meant for open-drain pads. The column outputs are active-high source enables. A prescaler, derived from the clock frequency and the target row refresh rate (780 Hz by default), sets how long each row stays on.

Each row slot starts with one blanking cycle in which every row and column is off, so an LED never shows the previous row's data. The channel vector is captured once per slot, at its start. Any change during the slot shows up at the next slot.

Top module: `led_matrix_scan`

## Requirements
- R1: While `rst_n` is low, all four `row_n` lines are high and both `col` lines are low. After release, the scan starts at row 0 with a blanking cycle.
- R2: At most one `row_n` line is low at any time. Rows take turns in the order 0, 1, 2, 3, 0, and so on.
- R3: Row r shows the channel pair held in `chan_state` bits 2r and 2r+1, where bit 0 is channel 1. `col[0]` carries the even bit, which is the lower-numbered channel. `col[1]` carries the odd bit.
- R4: A column is driven high only while a row is on and the captured channel for that column is 1. Both columns are low whenever no row is on.
- R5: The first cycle of every row slot is a blanking cycle with all rows high. A row never changes to another row without a blanking cycle in between.
- R6: Every row slot lasts `CLK_HZ/(4*REFRESH_HZ)` clock cycles, which gives each row a quarter of the scan period. The row is on for all of those cycles except the blanking cycle.
- R7: The channel vector is captured at the clock edge that ends a slot's blanking cycle. Changes to `chan_state` later in the slot leave `col` unchanged until the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_state | input | 8 | On/off state of the channels; bit 0 is channel 1 |
| row_n | output | 4 | Row sink enables, active low |
| col | output | 2 | Column source enables, active high |

## Verification
The bench drives a set of patterns: all off, all on, a single low channel, a single high channel, and alternating bits. For each pattern it checks every cycle of a full frame. This exposes a swapped column, which would light the wrong LED of a pair, and a row mapped to the wrong pair.

In the middle of every slot the bench applies the inverted vector. A design that follows `chan_state` directly, instead of holding the captured pair, would flip the columns at that point.

Every cycle is checked against the expected row and blanking position. A missing blank cycle, or a slot one cycle too long or too short, therefore shows up as a row that is on at the wrong time.

Finally, a reset in the middle of a slot must blank the outputs at once and restart the scan at row 0.

// File: rtl/led_matrix_scan.sv
module led_matrix_scan #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int REFRESH_HZ = 780,
  parameter int ROWS       = 4,
  parameter int COLS       = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROWS*COLS-1:0] chan_state,
  output logic [ROWS-1:0]      row_n,
  output logic [COLS-1:0]      col
);
  localparam int SLOT  = CLK_HZ / (REFRESH_HZ * ROWS);
  localparam int CNT_W = (SLOT > 2) ? $clog2(SLOT) : 1;
  localparam int ROW_W = (ROWS > 2) ? $clog2(ROWS) : 1;

  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] ridx;
  logic [COLS-1:0]  pair;
  logic             active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ridx <= '0;
      pair <= '0;
    end else begin
      if (cnt == CNT_W'(SLOT - 1)) begin
        cnt  <= '0;
        ridx <= (ridx == ROW_W'(ROWS - 1)) ? '0 : ridx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (cnt == '0)
        pair <= chan_state[ridx*COLS +: COLS];
    end
  end

  assign active = (cnt != '0);
  assign row_n  = active ? ~(ROWS'(1) << ridx) : '1;
  assign col    = active ? pair : '0;

  AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~row_n)); // R2
  AST_DARK_COLS: assert property (@(posedge clk) disable iff (!rst_n)
    (&row_n) |-> (col == '0)); // R4
  AST_BLANK_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&row_n) && !(&$past(row_n))) |-> (row_n == $past(row_n))); // R5
  AST_HOLD_COLS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&row_n) && !(&$past(row_n))) |-> $stable(col)); // R7
endmodule

// File: tb/sim_led_matrix_scan.sv
module sim_led_matrix_scan;
  localparam int S = 6;
  localparam logic [7:0] VEC [6] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'hA5, 8'h3C};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] chan_state = 8'h00;
  logic [3:0] row_n;
  logic [1:0] col;
  int total = 0;
  int bad = 0;
  bit done = 0;

  led_matrix_scan #(.CLK_HZ(S * 4), .REFRESH_HZ(1), .ROWS(4), .COLS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .chan_state(chan_state), .row_n(row_n), .col(col));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [3:0] er, input logic [1:0] ec);
    total++;
    if (row_n !== er || col !== ec) begin
      bad++;
      $display("FAIL %s: row_n=%b col=%b expected row_n=%b col=%b", req, row_n, col, er, ec);
    end
  endtask

  // one full frame: R2 R3 R5 R6 checked every cycle, R7 via mid-slot inversion
  task automatic run_frame(input logic [7:0] v);
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < S; p++) begin
        if (p == 0) begin
          chan_state = v;
          chk("R5 blank slot start", 4'b1111, 2'b00);
        end else begin
          chk("R2/R3/R6/R7 active row", 4'b1111 & ~(4'b0001 << r), v[2*r +: 2]);
        end
        if (p == S / 2) chan_state = ~v;
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: expired expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset state", 4'b1111, 2'b00);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) run_frame(VEC[i]);
    // R4: all-off vector keeps columns dark across a frame
    run_frame(8'h00);
    // R1: reset mid-slot blanks at once and restarts at row 0
    run_frame(8'h5A);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset mid-slot", 4'b1111, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    run_frame(8'h0C);
    run_frame(8'hC3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule